// File: doc/BRIEF.md
# Stack Word Transfer Sequencer

This block performs the four stack operations of a small 64-bit processor: push a register value, pop into a register, call a subroutine and return from one. It owns the stack pointer. It moves each 8-byte word across a byte-wide data memory port, one byte per cycle. The stack grows downward, and the pointer always holds the address of the top element. A store therefore goes to the pointer minus eight, and a load comes from the pointer itself. The pointer takes its new value only when the whole word has moved.

The surrounding pipeline selects the operation and supplies a source value. For push that value is a register operand; for call it is the return address. The pipeline also supplies a call target, then pulses `start`. When the sequencer finishes, it raises `done` for one cycle. At that point the popped value, the stack pointer, the program counter and a status code are all valid. The memory answers in the same cycle, with read data and an address-error flag. An address error ends the operation at once and leaves the architectural state as it was.

Top module: `stk_seq`

## Requirements
- R1: After reset, `sp` equals the parameter SP_INIT, `pc` and `pop_val` are zero, `status` is 1 (normal), and `busy` and `done` are low.
- R2: Operation code 0 (push) writes `src_val` to the 8 bytes that start at `sp`-8, least significant byte at the lowest address. It then leaves `sp` at `sp`-8 and `pc` unchanged.
- R3: Operation code 1 (pop) reads the 8 bytes that start at `sp` as a little-endian word. It presents that word on `pop_val` and leaves `sp` at `sp`+8.
- R4: Operation code 2 (call) stores `src_val` as the return address, exactly as a push does. It leaves `sp` at `sp`-8 and sets `pc` to `call_tgt`.
- R5: Operation code 3 (ret) reads a word exactly as a pop does. It sets `pc` to that word, leaves `sp` at `sp`+8, and does not change `pop_val`.
- R6: An accepted operation makes one memory access per cycle for up to 8 consecutive cycles, beginning in the cycle after `start` is sampled, at ascending addresses. `mem_we` is high for push and call, `mem_re` is high for pop and ret, and the two are never high together.
- R7: `done` is a single-cycle pulse in the cycle after the last byte access, with `busy` low. `sp`, `pc`, `pop_val` and `status` (1 on success) already show the result in that cycle.
- R8: If `mem_err` is high during a byte access, no further bytes are accessed. `done` follows in the next cycle with `status` 3, and `sp`, `pc` and `pop_val` keep their earlier values.
- R9: `start` is ignored while `busy` is high. It is accepted whenever `busy` is low, including the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 2 | 0 push, 1 pop, 2 call, 3 ret |
| src_val | input | 64 | Word to store (register value or return address) |
| call_tgt | input | 64 | Destination of a call |
| mem_addr | output | 64 | Byte address of the current access |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Byte written |
| mem_rdata | input | 8 | Byte read, valid in the same cycle |
| mem_err | input | 1 | Current byte address is invalid |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_val | output | 64 | Last word popped |
| sp | output | 64 | Stack pointer |
| pc | output | 64 | Program counter after call or ret |
| status | output | 3 | 1 normal, 3 bad data address |

## Verification
Words with a distinct value in every byte are pushed and popped. This separates correct little-endian order from swapped or shifted lanes. A call followed by a ret checks that the return address goes around the stack and lands in `pc` while `pop_val` stays put. Address errors are injected on the first byte and in the middle of a word, which tests abort timing and that state is kept. A `start` raised while busy, and one held through a `done` cycle, separate ignored requests from back-to-back accepted ones.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_AOK = 3'd1,
    ST_ADR = 3'd3
  } stk_stat_e;

  function automatic logic op_stores(stk_op_e o);
    return (o == OP_PUSH) || (o == OP_CALL);
  endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
  parameter int NBYTES = 8,
  localparam int CW = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mem_err,
  output logic          launch,
  output logic          finish_ok,
  output logic          abort,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cnt
);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    launch    = start && !busy_q;
    abort     = busy_q && mem_err;
    finish_ok = busy_q && !mem_err && (cnt_q == CW'(NBYTES - 1));
    done_d    = abort || finish_ok;
    busy_d    = busy_q;
    cnt_d     = cnt_q;
    if (launch) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (done_d) busy_d = 1'b0;
      else        cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign cnt  = cnt_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !busy_q)); // R7

endmodule

// File: rtl/stk_rd_gather.sv
module stk_rd_gather #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic [7:0]   byte_in,
  output logic [W-1:0] word
);

  logic [W-1:0] acc_q;

  // newest byte enters at the top; after W/8 shifts the first byte sits lowest
  assign word = {byte_in, acc_q[W-1:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (shift_en) acc_q <= word;
  end

endmodule

// File: rtl/stk_wr_scatter.sv
module stk_wr_scatter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  output logic [7:0]   byte_out
);

  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)          sh_d = load_val;
    else if (shift_en) sh_d = sh_q >> 8;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign byte_out = sh_q[7:0];

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int          WORD_W  = 64,
  parameter logic [63:0] SP_INIT = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [WORD_W-1:0] src_val,
  input  logic [WORD_W-1:0] call_tgt,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_err,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] pop_val,
  output logic [WORD_W-1:0] sp,
  output logic [WORD_W-1:0] pc,
  output logic [2:0]        status
);

  localparam int NBYTES = WORD_W / 8;
  localparam int CW     = $clog2(NBYTES);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(NBYTES);

  logic              launch, finish_ok, abort;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] word;

  stk_op_e           op_q, op_d;
  logic [WORD_W-1:0] base_q, base_d;
  logic [WORD_W-1:0] tgt_q, tgt_d;
  logic [WORD_W-1:0] sp_q, sp_d;
  logic [WORD_W-1:0] pc_q, pc_d;
  logic [WORD_W-1:0] pop_q, pop_d;
  stk_stat_e         stat_q, stat_d;

  stk_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_err   (mem_err),
    .launch    (launch),
    .finish_ok (finish_ok),
    .abort     (abort),
    .busy      (busy),
    .done      (done),
    .cnt       (cnt)
  );

  stk_rd_gather #(.W(WORD_W)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (mem_re && !mem_err),
    .byte_in  (mem_rdata),
    .word     (word)
  );

  stk_wr_scatter #(.W(WORD_W)) u_scatter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .load_val (src_val),
    .shift_en (busy),
    .byte_out (mem_wdata)
  );

  assign mem_addr = base_q + WORD_W'(cnt);
  assign mem_we   = busy && op_stores(op_q);
  assign mem_re   = busy && !op_stores(op_q);

  always_comb begin
    op_d   = op_q;
    base_d = base_q;
    tgt_d  = tgt_q;
    sp_d   = sp_q;
    pc_d   = pc_q;
    pop_d  = pop_q;
    stat_d = stat_q;
    if (launch) begin
      op_d   = stk_op_e'(op);
      tgt_d  = call_tgt;
      base_d = op_stores(stk_op_e'(op)) ? (sp_q - STEP) : sp_q;
    end
    if (abort) stat_d = ST_ADR;
    if (finish_ok) begin
      stat_d = ST_AOK;
      case (op_q)
        OP_PUSH: sp_d = base_q;
        OP_POP: begin
          sp_d  = sp_q + STEP;
          pop_d = word;
        end
        OP_CALL: begin
          sp_d = base_q;
          pc_d = tgt_q;
        end
        default: begin
          sp_d = sp_q + STEP;
          pc_d = word;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PUSH;
      base_q <= '0;
      tgt_q  <= '0;
      sp_q   <= WORD_W'(SP_INIT);
      pc_q   <= '0;
      pop_q  <= '0;
      stat_q <= ST_AOK;
    end else begin
      op_q   <= op_d;
      base_q <= base_d;
      tgt_q  <= tgt_d;
      sp_q   <= sp_d;
      pc_q   <= pc_d;
      pop_q  <= pop_d;
      stat_q <= stat_d;
    end
  end

  assign sp      = sp_q;
  assign pc      = pc_q;
  assign pop_val = pop_q;
  assign status  = stat_q;

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R6
  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R6
  AST_SP_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(sp_q)); // R2
  AST_SP_STEP_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stat_q == ST_AOK) |->
      ((sp_q == $past(sp_q) + STEP) || (sp_q == $past(sp_q) - STEP))); // R3
  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stat_q == ST_ADR) |->
      ($stable(sp_q) && $stable(pc_q) && $stable(pop_q))); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(op_q) && $stable(base_q))); // R9

endmodule

// File: tb/stk_seq_bench.sv
module stk_seq_bench;

  localparam logic [63:0] SPI = 64'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [63:0] src_val = '0;
  logic [63:0] call_tgt = '0;
  logic [63:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_err;
  logic        busy, done;
  logic [63:0] pop_val, sp, pc;
  logic [2:0]  status;

  int n_chk = 0;
  int n_fail = 0;
  bit live = 1'b0;

  logic [7:0]  mem [0:255];
  logic [63:0] err_lo = 64'h1;
  logic [63:0] err_hi = 64'h0;

  always #2.5 clk = ~clk;

  stk_seq #(.WORD_W(64), .SP_INIT(SPI)) u_stk_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_val(src_val), .call_tgt(call_tgt),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .busy(busy), .done(done), .pop_val(pop_val), .sp(sp), .pc(pc),
    .status(status)
  );

  function automatic bit addr_ok(logic [63:0] a);
    return (a >= 64'h100) && (a <= 64'h1FF) && !((a >= err_lo) && (a <= err_hi));
  endfunction

  always_comb begin
    mem_err   = (mem_re || mem_we) && !addr_ok(mem_addr);
    mem_rdata = (mem_re && addr_ok(mem_addr)) ? mem[mem_addr[7:0]] : 8'h00;
  end

  always @(posedge clk)
    if (mem_we && addr_ok(mem_addr)) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_busy, m_done;
  int          m_cnt;
  logic [1:0]  m_op;
  logic [63:0] m_src, m_tgt, m_base, m_acc, m_sp, m_pc, m_pop;
  logic [2:0]  m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_op = 0;
      m_src = 0; m_tgt = 0; m_base = 0; m_acc = 0;
      m_sp = SPI; m_pc = 0; m_pop = 0; m_stat = 3'd1;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_op = op; m_src = src_val; m_tgt = call_tgt;
          m_base = (op == 2'd0 || op == 2'd2) ? m_sp - 64'd8 : m_sp;
          m_busy = 1; m_cnt = 0;
        end
      end else begin
        logic [63:0] a;
        a = m_base + 64'(m_cnt);
        if (!addr_ok(a)) begin
          m_busy = 0; m_done = 1; m_stat = 3'd3;
        end else begin
          if (m_op == 2'd1 || m_op == 2'd3) m_acc[8*m_cnt +: 8] = mem[a[7:0]];
          if (m_cnt == 7) begin
            m_busy = 0; m_done = 1; m_stat = 3'd1;
            case (m_op)
              2'd0: m_sp = m_base;
              2'd1: begin m_pop = m_acc; m_sp = m_sp + 64'd8; end
              2'd2: begin m_sp = m_base; m_pc = m_tgt; end
              default: begin m_pc = m_acc; m_sp = m_sp + 64'd8; end
            endcase
          end else m_cnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && live) begin
      chk(busy == m_busy, "R9", "busy", 64'(busy), 64'(m_busy));
      chk(done == m_done, "R7", "done", 64'(done), 64'(m_done));
      chk(sp == m_sp, "R2", "sp", sp, m_sp);
      chk(pc == m_pc, "R4", "pc", pc, m_pc);
      chk(pop_val == m_pop, "R3", "pop_val", pop_val, m_pop);
      chk(status == m_stat, "R8", "status", 64'(status), 64'(m_stat));
      if (m_busy) begin
        chk(mem_addr == m_base + 64'(m_cnt), "R6", "mem_addr", mem_addr, m_base + 64'(m_cnt));
        chk(mem_we == (m_op == 2'd0 || m_op == 2'd2), "R6", "mem_we", 64'(mem_we), 64'(m_op == 2'd0 || m_op == 2'd2));
        chk(mem_re == (m_op == 2'd1 || m_op == 2'd3), "R6", "mem_re", 64'(mem_re), 64'(m_op == 2'd1 || m_op == 2'd3));
        if (m_op == 2'd0 || m_op == 2'd2)
          chk(mem_wdata == m_src[8*m_cnt +: 8], "R2", "mem_wdata", 64'(mem_wdata), 64'(m_src[8*m_cnt +: 8]));
      end else begin
        chk(!mem_we && !mem_re, "R8", "idle strobes", 64'({mem_we, mem_re}), 64'h0);
      end
    end
  end

  task automatic do_op(input logic [1:0] o, input logic [63:0] s, input logic [63:0] t);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; op = o; src_val = s; call_tgt = t;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  function automatic logic [63:0] rd_word(logic [63:0] a);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[8*i +: 8] = mem[a[7:0] + 8'(i)];
    return w;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sp == SPI, "R1", "sp", sp, SPI);
    chk(pc == 0 && pop_val == 0, "R1", "pc|pop", pc | pop_val, 64'h0);
    chk(status == 3'd1, "R1", "status", 64'(status), 64'h1);
    chk(!busy && !done, "R1", "busy/done", 64'({busy, done}), 64'h0);
    rst_n = 1'b1;
    live = 1'b1;

    // R2: push, little-endian layout
    do_op(2'd0, 64'h1122334455667788, 64'h0);
    chk(sp == 64'h1F8, "R2", "sp after push", sp, 64'h1F8);
    chk(mem[8'hF8] == 8'h88 && mem[8'hFF] == 8'h11, "R2", "byte order",
        64'({mem[8'hF8], mem[8'hFF]}), 64'h8811);

    // R9: start raised while busy is ignored
    @(negedge clk);
    start = 1'b1; op = 2'd0; src_val = 64'hA5A50000FFFF0001;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; op = 2'd1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!busy, "R9", "no extra op", 64'(busy), 64'h0);
    chk(sp == 64'h1F0, "R9", "sp after ignored start", sp, 64'h1F0);

    // R3: pop
    do_op(2'd1, 64'h0, 64'h0);
    chk(pop_val == 64'hA5A50000FFFF0001, "R3", "pop value", pop_val, 64'hA5A50000FFFF0001);
    chk(sp == 64'h1F8, "R3", "sp after pop", sp, 64'h1F8);

    // R4: call
    do_op(2'd2, 64'h40, 64'h123);
    chk(pc == 64'h123, "R4", "pc after call", pc, 64'h123);
    chk(rd_word(64'h1F0) == 64'h40, "R4", "return addr", rd_word(64'h1F0), 64'h40);

    // R5: ret
    do_op(2'd3, 64'h0, 64'h0);
    chk(pc == 64'h40 && sp == 64'h1F8, "R5", "pc after ret", pc, 64'h40);
    chk(pop_val == 64'hA5A50000FFFF0001, "R5", "pop_val kept", pop_val, 64'hA5A50000FFFF0001);

    // R8: error in the middle of a word
    err_lo = 64'h1F4; err_hi = 64'h1F4;
    do_op(2'd0, 64'hDEADBEEFCAFEF00D, 64'h0);
    chk(status == 3'd3, "R8", "status mid-word", 64'(status), 64'h3);
    chk(sp == 64'h1F8, "R8", "sp kept", sp, 64'h1F8);
    err_lo = 64'h1; err_hi = 64'h0;

    // R7: success restores normal status
    do_op(2'd1, 64'h0, 64'h0);
    chk(status == 3'd1, "R7", "status ok", 64'(status), 64'h1);
    chk(pop_val == 64'h1122334455667788, "R7", "pop value", pop_val, 64'h1122334455667788);

    // R8: error on the first byte (sp at window top)
    do_op(2'd1, 64'h0, 64'h0);
    chk(status == 3'd3 && sp == SPI, "R8", "first-byte abort", sp, SPI);
    chk(pop_val == 64'h1122334455667788, "R8", "pop_val kept", pop_val, 64'h1122334455667788);

    // R9: start held through a done cycle starts the next push at once
    @(negedge clk);
    start = 1'b1; op = 2'd0; src_val = 64'h0102030405060708;
    @(negedge clk);
    while (!done) @(negedge clk);
    src_val = 64'h1112131415161718;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9", "back-to-back accept", 64'(busy), 64'h1);
    while (!done) @(negedge clk);
    chk(sp == 64'h1F0, "R9", "sp after two pushes", sp, 64'h1F0);
    chk(rd_word(64'h1F0) == 64'h1112131415161718, "R2", "second word",
        rd_word(64'h1F0), 64'h1112131415161718);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule